// File: doc/BRIEF.md
# Demand-driven two-road traffic light controller

This block drives the lights at a crossing of a North-South road and an East-West road. Each road shows green or red, and exactly one road has green at any time. A car detector on each road reports whether a vehicle is present.

A free-running cycle counter makes a one-cycle update pulse once every `TICK_CYCLES` clocks. The default is 30 seconds at 50 MHz. The lights are re-decided only on that pulse. The green moves to the other road only when the road that is currently red has a car waiting. Otherwise the current road keeps its green.

The detectors are looked at only in the cycle of the pulse. A synchronous reset gives North-South the green and restarts the counter.

Top module: `xing_light_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes to North-South green and clears the period counter. The first update after `rst` falls happens on the `TICK_CYCLES`-th rising edge after the last edge with `rst` high.
- R2: On every cycle exactly one of `ns_green` and `ew_green` is 1. `ns_red` is always the inverse of `ns_green`, and `ew_red` is always the inverse of `ew_green`.
- R3: After the first update, later updates happen exactly every `TICK_CYCLES` rising edges.
- R4: At an update with North-South green and `car_ew` = 1, East-West becomes green, whatever `car_ns` shows.
- R5: At an update with North-South green and `car_ew` = 0, North-South keeps the green, whatever `car_ns` shows.
- R6: At an update with East-West green and `car_ns` = 1, North-South becomes green, whatever `car_ew` shows.
- R7: At an update with East-West green and `car_ns` = 0, East-West keeps the green, whatever `car_ew` shows.
- R8: At a clock edge that is not an update, the lights do not change, whatever the detectors show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_ns | input | 1 | A car is present on the North-South road |
| car_ew | input | 1 | A car is present on the East-West road |
| ns_green | output | 1 | North-South green lamp |
| ns_red | output | 1 | North-South red lamp |
| ew_green | output | 1 | East-West green lamp |
| ew_red | output | 1 | East-West red lamp |

## Verification
The bench places short detector pulses between two update pulses. A controller that sampled the detectors continuously would then switch at the wrong moment, or switch with no car present at the update.

The bench also holds both detectors high across updates. A design that looked at its own road's detector would then keep the green, or would toggle wrongly.

It resets in the middle of a period while East-West is green. A counter that was not cleared would move the first update away from the `TICK_CYCLES`-th edge after reset.

Every cycle is checked for exactly one green road. This catches any decode that lights both roads or neither.

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl #(
  parameter int TICK_CYCLES = 1_500_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic car_ns,
  input  logic car_ew,
  output logic ns_green,
  output logic ns_red,
  output logic ew_green,
  output logic ew_red
);
  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  typedef enum logic {NS_GO = 1'b0, EW_GO = 1'b1} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          upd;
  logic          swap;

  assign upd  = (cnt == LAST);
  assign swap = (phase == NS_GO) ? car_ew : car_ns;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= NS_GO;
    end else begin
      cnt <= upd ? '0 : cnt + 1'b1;
      if (upd && swap)
        phase <= (phase == NS_GO) ? EW_GO : NS_GO;
    end
  end

  assign ns_green = (phase == NS_GO);
  assign ew_green = (phase == EW_GO);
  assign ns_red   = ~ns_green;
  assign ew_red   = ~ew_green;
endmodule

module xing_light_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic car_ns,
  input logic car_ew,
  input logic upd,
  input logic ns_green,
  input logic ns_red,
  input logic ew_green,
  input logic ew_red
);
  AST_ONE_GREEN: assert property (@(posedge clk) disable iff (rst) $countones({ns_green, ew_green}) == 1); // R2
  AST_RED_INV: assert property (@(posedge clk) disable iff (rst) (ns_red != ns_green) && (ew_red != ew_green)); // R2
  AST_GO_EW: assert property (@(posedge clk) disable iff (rst) upd && ns_green && car_ew |=> ew_green); // R4
  AST_STAY_NS: assert property (@(posedge clk) disable iff (rst) upd && ns_green && !car_ew |=> ns_green); // R5
  AST_GO_NS: assert property (@(posedge clk) disable iff (rst) upd && ew_green && car_ns |=> ns_green); // R6
  AST_STAY_EW: assert property (@(posedge clk) disable iff (rst) upd && ew_green && !car_ns |=> ew_green); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !upd |=> $stable(ns_green)); // R8
endmodule

bind xing_light_ctrl xing_light_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .car_ns(car_ns), .car_ew(car_ew), .upd(upd),
  .ns_green(ns_green), .ns_red(ns_red), .ew_green(ew_green), .ew_red(ew_red)
);

// File: tb/xing_light_ctrl_test.sv
module xing_light_ctrl_test;
  localparam int PERIOD = 10;
  localparam int T = 5;

  logic clk = 0, rst = 1, car_ns = 0, car_ew = 0;
  logic ns_green, ns_red, ew_green, ew_red;
  int checks = 0, errors = 0, edges = 0;
  logic exp_ew = 0;

  always #(PERIOD/2) clk = ~clk;

  xing_light_ctrl #(.TICK_CYCLES(T)) uut (
    .clk(clk), .rst(rst), .car_ns(car_ns), .car_ew(car_ew),
    .ns_green(ns_green), .ns_red(ns_red), .ew_green(ew_green), .ew_red(ew_red)
  );

  function automatic logic next_ew(logic cur_ew, logic cn, logic ce);
    return cur_ew ? !cn : ce;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at edge %0d", tag, act, exp, edges);
    end
  endtask

  task automatic step(logic cn, logic ce, logic r = 0);
    string tag;
    logic prev;
    car_ns = cn; car_ew = ce; rst = r;
    @(posedge clk);
    prev = exp_ew;
    if (r) begin
      exp_ew = 0; edges = 0; tag = "R1";
    end else begin
      edges++;
      if (edges % T == 0) begin
        exp_ew = next_ew(prev, cn, ce);
        tag = prev ? (cn ? "R6" : "R7") : (ce ? "R4" : "R5");
        if (edges == T) tag = {tag, "/R1"};
        else tag = {tag, "/R3"};
      end else tag = "R8";
    end
    @(negedge clk);
    chk("R2", ns_green ^ ew_green, 1'b1);
    chk("R2", (ns_red == ~ns_green) && (ew_red == ~ew_green), 1'b1);
    chk(tag, ew_green, exp_ew);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    step(1, 1, 1); step(0, 0, 1);
    chk("R1", ns_green, 1'b1);
    for (int i = 0; i < 2*T; i++) step(1, 0);
    for (int i = 0; i < T-1; i++) step(0, 1);
    step(0, 0);
    for (int i = 0; i < T-1; i++) step(1, 1);
    step(1, 1);
    for (int i = 0; i < T-1; i++) step(0, 0);
    step(1, 1);
    step(0, 0); step(0, 0);
    for (int i = 0; i < T-3; i++) step(0, 0);
    step(0, 1);
    step(0, 0); step(0, 1, 1);
    chk("R1", ns_green, 1'b1);
    for (int i = 0; i < T-1; i++) step(0, 0);
    step(0, 1);
    chk("R1", ew_green, 1'b1);
    for (int i = 0; i < T-1; i++) step(1, 1);
    step(0, 1);
    for (int i = 0; i < 400; i++) step(1'($urandom), 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule